// File: doc/BRIEF.md
# Asynchronous Host Port Slave

This block lets an external host reach an on-chip memory or register bus through an asynchronous strobe interface. Address and data share one 16-bit bus. A mode pin selects whether each data transfer carries a full 16-bit word or a single byte. The host strobes (chip select, address latch, read, write) arrive with no relation to the block clock. They pass through a two-stage synchroniser before any logic uses them.

The host loads an address in one of two ways, and the block tells them apart from the strobes alone. In the first, the address-latch strobe is raised on its own. In the second, the write strobe is raised while the address-latch strobe is high. After each completed word the address steps by one, so the host can stream data without sending a new address. Writes go into a small buffer and are drained onto the internal bus. A read waits until every buffered write has been committed, then fetches one word. An acknowledge output tells the host when it may end its strobe. Its active level is sampled from a pin during reset. A style pin selects between two forms of this output: an acknowledge form and a ready form.

The internal side is a valid/ready request channel. The block raises `mem_req_valid` and keeps the request steady until `mem_req_ready` is high on a clock edge. That edge is the transfer. Back-pressure from the bus leaves the request in place and fills the write buffer. Read data returns on `mem_rsp_valid` exactly one cycle after the read request is accepted, and the block accepts it without stalling.

Top module: `hostif_slave`

## Requirements
- R1: The acknowledge active level is taken from `ack_pol_pin` while `rst_n` is low (1 = active high, 0 = active low). Changes on that pin after reset have no effect.
- R2: With `ready_style`=0, the acknowledge is active only while a host strobe is held and its access has completed. With `ready_style`=1, it is active whenever no held strobe is blocked, including when the port is idle.
- R3: Raising the address-latch strobe while the write strobe is low loads the bus value as the current address.
- R4: A write strobe given while the address-latch strobe is high loads the bus value as the current address. It is acknowledged and causes no internal bus transfer.
- R5: With `wide_mode`=1, each host write produces one internal write of the 16-bit bus value at the current address, and the address then steps by one.
- R6: With `wide_mode`=0, the host writes the low byte (bus bits 7:0) first and then the high byte. The pair produces a single internal write of {high, low}, and the address then steps by one.
- R7: A host read returns the word fetched from the current address. With `wide_mode`=1, the full word is driven on `h_ad_out` and the address steps by one. With `wide_mode`=0, the low byte is driven first and the high byte second, both in bits 7:0 with bits 15:8 zero. Each byte pair uses one internal read, and the address steps after the high byte.
- R8: The write buffer holds two words. A word write that finds it full is not acknowledged until an entry drains.
- R9: A host read is not acknowledged, and issues no internal read, until every buffered write has been transferred. Internal transfers follow host order.
- R10: An internal request that is not accepted stays valid with unchanged address, write flag and data.
- R11: Host strobes pass through two synchronising flops and a registered acknowledge. The acknowledge cannot respond within two clock cycles of a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| ack_pol_pin | input | 1 | Acknowledge active level, sampled during reset |
| ready_style | input | 1 | 0 = acknowledge form, 1 = ready form |
| wide_mode | input | 1 | 1 = 16-bit transfers, 0 = byte transfers |
| h_cs | input | 1 | Host chip select, asynchronous, active high |
| h_ale | input | 1 | Host address-latch strobe, asynchronous |
| h_rd | input | 1 | Host read strobe, asynchronous |
| h_wr | input | 1 | Host write strobe, asynchronous |
| h_ad_in | input | 16 | Shared address/data bus, host to block |
| h_ad_out | output | 16 | Read data toward the host |
| h_ad_oe | output | 1 | Bus drive enable for read data |
| h_ack | output | 1 | Acknowledge / ready toward the host |
| mem_req_valid | output | 1 | Internal request valid |
| mem_req_ready | input | 1 | Internal request accepted |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Request word address |
| mem_wdata | output | 16 | Write data |
| mem_rsp_valid | input | 1 | Read data valid, one cycle after read acceptance |
| mem_rsp_data | input | 16 | Read data |

## Verification
A wrong current address shows on the next internal transfer. It appears as a mismatched `mem_addr` on the very next request, and the scoreboard compares every request at the moment it is accepted. A stuck byte phase causes a missing or doubled internal transfer, which the scoreboard reports at that transfer or as a leftover entry at the end. A bad buffer count shows within one host strobe, either as an acknowledge during a full-buffer stall or as a read that overtakes a write. A wrong polarity latch is visible on `h_ack` one cycle after reset is released.

// File: rtl/hostif_pkg.sv
package hostif_pkg;
  parameter int unsigned HP_DW = 16;
  parameter int unsigned HP_BW = 8;

  typedef enum logic [1:0] {
    RD_IDLE = 2'd0,
    RD_REQ  = 2'd1,
    RD_WAIT = 2'd2,
    RD_HAVE = 2'd3
  } rd_state_e;
endpackage

// File: rtl/hostif_sync.sv
module hostif_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d_async;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/hostif_wbuf.sv
module hostif_wbuf #(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         not_empty,
  output logic         full
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wp_q <= ptr_next(wp_q);
      if (pop)  rp_q <= ptr_next(rp_q);
      if (push && !pop)      cnt_q <= cnt_q + 1'b1;
      else if (pop && !push) cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem_q[wp_q] <= din;
  end

  assign dout      = mem_q[rp_q];
  assign not_empty = (cnt_q != '0);
  assign full      = (cnt_q == CW'(DEPTH));

  // R8: the buffer never takes an entry beyond its depth
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (!full || pop));
  // R8: the buffer is never drained when empty
  a_r8_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> not_empty);
endmodule

// File: rtl/hostif_slave.sv
module hostif_slave
  import hostif_pkg::*;
#(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned WBUF_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ack_pol_pin,
  input  logic              ready_style,
  input  logic              wide_mode,
  input  logic              h_cs,
  input  logic              h_ale,
  input  logic              h_rd,
  input  logic              h_wr,
  input  logic [HP_DW-1:0]  h_ad_in,
  output logic [HP_DW-1:0]  h_ad_out,
  output logic              h_ad_oe,
  output logic              h_ack,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [HP_DW-1:0]  mem_wdata,
  input  logic              mem_rsp_valid,
  input  logic [HP_DW-1:0]  mem_rsp_data
);
  localparam int unsigned ENT_W = ADDR_W + HP_DW;

  // synchronised strobes
  logic [3:0] strb_s;
  logic s_cs, s_ale, s_rd, s_wr;
  hostif_sync #(.W(4), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d_async({h_cs, h_ale, h_rd, h_wr}),
    .q_sync(strb_s)
  );
  assign {s_cs, s_ale, s_rd, s_wr} = strb_s;

  // state
  logic [ADDR_W-1:0] addr_q;
  logic              byte_hi_q;
  logic [HP_BW-1:0]  lo_q;
  logic              wr_done_q;
  rd_state_e         rd_st_q;
  logic [HP_DW-1:0]  rd_word_q;
  logic              ack_q;
  logic              pol_q;

  // write buffer
  logic             wb_push, wb_pop, wb_ne, wb_full;
  logic [ENT_W-1:0] wb_din, wb_dout;

  hostif_wbuf #(.W(ENT_W), .DEPTH(WBUF_DEPTH)) u_wbuf (
    .clk(clk), .rst_n(rst_n),
    .push(wb_push), .din(wb_din),
    .pop(wb_pop), .dout(wb_dout),
    .not_empty(wb_ne), .full(wb_full)
  );

  // host side decode
  logic wr_act, rd_act, wr_addr_cyc, wr_data_cyc, lo_only, wr_accept;
  logic rd_issue, rd_ok, blk_wr, blk_rd, ack_act;

  always_comb begin
    wr_act      = s_cs & s_wr;
    rd_act      = s_cs & s_rd;
    wr_addr_cyc = wr_act & s_ale & ~wr_done_q;
    wr_data_cyc = wr_act & ~s_ale & ~wr_done_q;
    lo_only     = ~wide_mode & ~byte_hi_q;
    wr_accept   = wr_data_cyc & (lo_only | ~wb_full);
    wb_push     = wr_accept & ~lo_only;
    wb_din      = {addr_q, wide_mode ? h_ad_in : {h_ad_in[HP_BW-1:0], lo_q}};
    rd_issue    = (rd_st_q == RD_REQ) & ~wb_ne;
    rd_ok       = (rd_st_q == RD_HAVE) & ~wb_ne;
    blk_wr      = wr_data_cyc & ~wr_accept;
    blk_rd      = rd_act & ~rd_ok;
    if (ready_style) ack_act = ~(blk_wr | blk_rd);
    else             ack_act = (wr_act & wr_done_q) | (rd_act & rd_ok);
  end

  // internal request channel: buffered writes first
  assign mem_req_valid = wb_ne | rd_issue;
  assign mem_we        = wb_ne;
  assign mem_addr      = wb_ne ? wb_dout[ENT_W-1:HP_DW] : addr_q;
  assign mem_wdata     = wb_dout[HP_DW-1:0];
  assign wb_pop        = wb_ne & mem_req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q    <= '0;
      byte_hi_q <= 1'b0;
      lo_q      <= '0;
      wr_done_q <= 1'b0;
      rd_st_q   <= RD_IDLE;
      rd_word_q <= '0;
      ack_q     <= 1'b0;
      pol_q     <= ack_pol_pin;
    end else begin
      ack_q <= ack_act;
      // write strobe and address capture
      if (wr_act) begin
        if (wr_addr_cyc) begin
          addr_q    <= h_ad_in[ADDR_W-1:0];
          byte_hi_q <= 1'b0;
          wr_done_q <= 1'b1;
        end else if (wr_accept) begin
          wr_done_q <= 1'b1;
          if (lo_only) begin
            lo_q      <= h_ad_in[HP_BW-1:0];
            byte_hi_q <= 1'b1;
          end else begin
            byte_hi_q <= 1'b0;
            addr_q    <= addr_q + 1'b1;
          end
        end
      end else begin
        wr_done_q <= 1'b0;
        if (s_cs && s_ale && !s_rd) begin
          addr_q    <= h_ad_in[ADDR_W-1:0];
          byte_hi_q <= 1'b0;
        end
      end
      // read sequencing
      unique case (rd_st_q)
        RD_IDLE: if (rd_act) rd_st_q <= (!wide_mode && byte_hi_q) ? RD_HAVE : RD_REQ;
        RD_REQ:  if (rd_issue && mem_req_ready) rd_st_q <= RD_WAIT;
        RD_WAIT: if (mem_rsp_valid) begin
          rd_word_q <= mem_rsp_data;
          rd_st_q   <= RD_HAVE;
        end
        RD_HAVE: if (!rd_act) begin
          rd_st_q <= RD_IDLE;
          if (wide_mode || byte_hi_q) begin
            addr_q    <= addr_q + 1'b1;
            byte_hi_q <= 1'b0;
          end else begin
            byte_hi_q <= 1'b1;
          end
        end
        default: rd_st_q <= RD_IDLE;
      endcase
    end
  end

  assign h_ad_oe  = rd_act & (rd_st_q == RD_HAVE);
  assign h_ad_out = wide_mode ? rd_word_q
                  : {{HP_BW{1'b0}}, byte_hi_q ? rd_word_q[HP_DW-1:HP_BW] : rd_word_q[HP_BW-1:0]};
  assign h_ack    = pol_q ? ack_q : ~ack_q;

  // R10: a stalled request holds still
  a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata)));
  // R1: polarity never moves outside reset
  a_r1_pol_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(pol_q));
  // R7: read data only arrives while a fetch is outstanding
  a_r7_rsp_when_waiting: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_valid |-> (rd_st_q == RD_WAIT));
  // R9: an outstanding fetch never coexists with buffered writes
  a_r9_read_after_writes: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_st_q == RD_WAIT) |-> !wb_ne);
endmodule

// File: tb/test_hostif_slave.sv
module test_hostif_slave;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ack_pol_pin = 1'b1;
  logic        ready_style = 1'b0;
  logic        wide_mode = 1'b1;
  logic        h_cs = 1'b0, h_ale = 1'b0, h_rd = 1'b0, h_wr = 1'b0;
  logic [15:0] h_ad_in = '0;
  logic [15:0] h_ad_out;
  logic        h_ad_oe, h_ack;
  logic        mem_req_valid, mem_we;
  logic        mem_req_ready = 1'b1;
  logic [15:0] mem_addr, mem_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic [15:0] mem_rsp_data = '0;

  int total = 0, bad = 0;
  logic pol_exp = 1'b1;
  logic [15:0] cur_addr = '0;
  logic [32:0] exp_q[$];

  always #2 clk = ~clk;

  hostif_slave i_hostif_slave (
    .clk(clk), .rst_n(rst_n), .ack_pol_pin(ack_pol_pin), .ready_style(ready_style),
    .wide_mode(wide_mode), .h_cs(h_cs), .h_ale(h_ale), .h_rd(h_rd), .h_wr(h_wr),
    .h_ad_in(h_ad_in), .h_ad_out(h_ad_out), .h_ad_oe(h_ad_oe), .h_ack(h_ack),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  function automatic logic [15:0] mem_f(input logic [15:0] a);
    return (a * 16'h0101) ^ 16'h5A3C;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit ack_on();
    return h_ack == pol_exp;
  endfunction

  // memory model: one-cycle read response
  always @(posedge clk) begin
    mem_rsp_valid <= rst_n && mem_req_valid && mem_req_ready && !mem_we;
    mem_rsp_data  <= mem_f(mem_addr);
  end

  // monitor: compare each accepted request with the scoreboard
  always @(negedge clk) begin
    if (rst_n && mem_req_valid && mem_req_ready) begin
      if (exp_q.size() == 0) begin
        chk(0, "R4/R5 unexpected transfer", {mem_we, mem_addr, mem_wdata[14:0]}, 0);
      end else begin
        logic [32:0] e;
        e = exp_q.pop_front();
        if (e[32]) chk({mem_we, mem_addr, mem_wdata} == e, "R5/R6/R9 write transfer",
                       {mem_we, mem_addr, mem_wdata[14:0]}, e[31:0]);
        else       chk(!mem_we && mem_addr == e[31:16], "R7/R9 read transfer",
                       {15'd0, mem_we, mem_addr}, {16'd0, e[31:16]});
      end
    end
  end

  task automatic wait_ack(output bit ok);
    ok = 0;
    repeat (5) @(negedge clk);
    for (int i = 0; i < 300; i++) begin
      if (ack_on()) begin ok = 1; break; end
      @(negedge clk);
    end
  endtask

  task automatic do_reset(input logic pol);
    rst_n = 1'b0; ack_pol_pin = pol; h_cs = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; ack_pol_pin = ~pol; pol_exp = pol; cur_addr = '0;
    repeat (2) @(negedge clk);
    h_cs = 1'b1;
  endtask

  task automatic ale_addr(input logic [15:0] a);
    h_ad_in = a; h_ale = 1'b1;
    repeat (4) @(negedge clk);
    h_ale = 1'b0;
    repeat (4) @(negedge clk);
    cur_addr = a;
  endtask

  task automatic acc_addr(input logic [15:0] a);
    bit ok;
    h_ad_in = a; h_ale = 1'b1; h_wr = 1'b1;
    wait_ack(ok);
    chk(ok, "R4 address cycle ack", {31'd0, ok}, 1);
    h_wr = 1'b0; h_ale = 1'b0;
    repeat (4) @(negedge clk);
    cur_addr = a;
  endtask

  task automatic hwrite(input logic [15:0] d, input string req);
    bit ok;
    h_ad_in = d; h_wr = 1'b1;
    wait_ack(ok);
    chk(ok, req, {31'd0, ok}, 1);
    h_wr = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic w16(input logic [15:0] d);
    exp_q.push_back({1'b1, cur_addr, d});
    cur_addr++;
    hwrite(d, "R5 word write ack");
  endtask

  task automatic w8pair(input logic [7:0] lo, input logic [7:0] hi);
    exp_q.push_back({1'b1, cur_addr, hi, lo});
    cur_addr++;
    hwrite({8'hEE, lo}, "R6 low byte ack");
    hwrite({8'hEE, hi}, "R6 high byte ack");
  endtask

  task automatic hread(output logic [15:0] d, input string req);
    bit ok;
    h_rd = 1'b1;
    wait_ack(ok);
    chk(ok, req, {31'd0, ok}, 1);
    d = h_ad_out;
    h_rd = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    bad++; total++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] d;
    bit ok;
    // R1: active-high polarity, pin toggled after reset
    do_reset(1'b1);
    chk(h_ack == 1'b0, "R1 idle ack, active high", {31'd0, h_ack}, 0);
    chk(h_ad_oe == 1'b0 && mem_req_valid == 1'b0, "R1 reset outputs idle",
        {30'd0, h_ad_oe, mem_req_valid}, 0);

    // R3 + R5: address latch mode, word writes with auto step
    ale_addr(16'h0010);
    w16(16'hA001);
    w16(16'hA002);

    // R4 + R11: address cycle mode, then a write with early-cycle check
    acc_addr(16'h0040);
    exp_q.push_back({1'b1, 16'h0040, 16'hB00B});
    cur_addr++;
    h_ad_in = 16'hB00B; h_wr = 1'b1;
    repeat (2) @(negedge clk);
    chk(!ack_on(), "R11 no ack within two cycles", {31'd0, h_ack}, {31'd0, ~pol_exp});
    wait_ack(ok);
    chk(ok, "R2 ack after write completes", {31'd0, ok}, 1);
    h_wr = 1'b0;
    repeat (4) @(negedge clk);
    chk(!ack_on(), "R2 ack drops after strobe", {31'd0, h_ack}, {31'd0, ~pol_exp});

    // R6: byte writes
    wide_mode = 1'b0;
    ale_addr(16'h0020);
    w8pair(8'h34, 8'h12);
    w8pair(8'h78, 8'h56);

    // R7: byte reads, one fetch per pair
    ale_addr(16'h0050);
    exp_q.push_back({1'b0, 16'h0050, 16'h0});
    hread(d, "R7 byte read low ack");
    chk(d == {8'h00, mem_f(16'h0050)[7:0]}, "R7 low byte", {16'd0, d}, {24'd0, mem_f(16'h0050)[7:0]});
    hread(d, "R7 byte read high ack");
    chk(d == {8'h00, mem_f(16'h0050)[15:8]}, "R7 high byte", {16'd0, d}, {24'd0, mem_f(16'h0050)[15:8]});
    exp_q.push_back({1'b0, 16'h0051, 16'h0});
    hread(d, "R7 byte read next ack");
    chk(d == {8'h00, mem_f(16'h0051)[7:0]}, "R7 next word low byte", {16'd0, d}, {24'd0, mem_f(16'h0051)[7:0]});
    hread(d, "R7 byte read next high ack");

    // R7: word reads with auto step
    wide_mode = 1'b1;
    ale_addr(16'h0030);
    exp_q.push_back({1'b0, 16'h0030, 16'h0});
    hread(d, "R7 word read ack");
    chk(d == mem_f(16'h0030), "R7 word read 0x30", {16'd0, d}, {16'd0, mem_f(16'h0030)});
    exp_q.push_back({1'b0, 16'h0031, 16'h0});
    hread(d, "R7 word read ack");
    chk(d == mem_f(16'h0031), "R7 word read 0x31", {16'd0, d}, {16'd0, mem_f(16'h0031)});

    // R8 + R10: stall the bus, fill the buffer
    ale_addr(16'h0060);
    @(negedge clk); mem_req_ready = 1'b0;
    w16(16'hC000);
    w16(16'hC001);
    exp_q.push_back({1'b1, 16'h0062, 16'hC002});
    cur_addr++;
    h_ad_in = 16'hC002; h_wr = 1'b1;
    repeat (20) @(negedge clk);
    chk(!ack_on(), "R8 no ack while buffer full", {31'd0, h_ack}, {31'd0, ~pol_exp});
    chk(mem_req_valid && mem_we && mem_addr == 16'h0060, "R10 stalled request held",
        {15'd0, mem_req_valid, mem_addr}, {16'd1, 16'h0060});
    mem_req_ready = 1'b1;
    wait_ack(ok);
    chk(ok, "R8 ack after drain", {31'd0, ok}, 1);
    h_wr = 1'b0;
    repeat (4) @(negedge clk);

    // R9: read behind a pending write
    mem_req_ready = 1'b0;
    w16(16'hD00D);
    exp_q.push_back({1'b0, 16'h0064, 16'h0});
    h_rd = 1'b1;
    repeat (15) @(negedge clk);
    chk(!ack_on(), "R9 read held behind write", {31'd0, h_ack}, {31'd0, ~pol_exp});
    mem_req_ready = 1'b1;
    wait_ack(ok);
    chk(ok, "R9 read ack after write", {31'd0, ok}, 1);
    chk(h_ad_out == mem_f(16'h0064), "R9 read data", {16'd0, h_ad_out}, {16'd0, mem_f(16'h0064)});
    h_rd = 1'b0;
    repeat (4) @(negedge clk);

    // R2: ready form
    ready_style = 1'b1;
    repeat (3) @(negedge clk);
    chk(ack_on(), "R2 ready form idle active", {31'd0, h_ack}, {31'd0, pol_exp});
    mem_req_ready = 1'b0;
    exp_q.push_back({1'b0, 16'h0065, 16'h0});
    h_rd = 1'b1;
    repeat (10) @(negedge clk);
    chk(!ack_on(), "R2 ready form blocked", {31'd0, h_ack}, {31'd0, ~pol_exp});
    mem_req_ready = 1'b1;
    wait_ack(ok);
    chk(ok && h_ad_out == mem_f(16'h0065), "R2 ready form read completes",
        {16'd0, h_ad_out}, {16'd0, mem_f(16'h0065)});
    h_rd = 1'b0;
    repeat (4) @(negedge clk);
    ready_style = 1'b0;

    chk(exp_q.size() == 0, "R4/R5 all expected transfers seen", exp_q.size(), 0);

    // R1: active-low polarity after a second reset
    do_reset(1'b0);
    repeat (2) @(negedge clk);
    chk(h_ack == 1'b1, "R1 idle ack, active low", {31'd0, h_ack}, 1);
    ale_addr(16'h0070);
    w16(16'hE00E);
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R5 write after second reset", exp_q.size(), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule